// File: doc/BRIEF.md
# ALU and Shifter Function Unit

This block is the purely combinational execution stage of a small datapath. It takes two operands, A and B, and a 4-bit function code. It returns one result word together with four status flags: overflow, carry, negative and zero. Internally it holds three sub-units:

- an adder whose second operand is a selectable transform of B, with a controllable carry-in;
- a four-way bitwise logic unit;
- a single-position shifter that acts on B and has serial fill inputs.

An output selector chooses the final result from among these sub-units.

The function code bits are shared between the sub-units rather than decoded separately. Code bit 0 is both the adder carry-in and the low select bit of the logic unit. Code bit 1 is both the high select of the logic unit and the low select of the adder's B transform. Code bit 3 separates arithmetic from logic. When code bits 3 and 2 are both set, the shifter is selected, and code bits 1:0 choose its operation. The shifter also outputs the bits that leave B at each end, so that a neighbouring block can chain shifts.

The enclosing datapath drives the operands from its register read ports and the code from its control word. It captures the result and flags at its own clock edge. This block contains no state.

Top module: `fu_unit`

## Requirements
- R1: Function codes 0 to 7 produce A plus Y plus bit 0 of the code, truncated to WIDTH bits. Y is selected by code bits 2:1: all zeros (00), B (01), bitwise NOT B (10), or all ones (11). This gives A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A.
- R2: For codes 0 to 7, the carry flag is the carry out of the WIDTH-bit addition in R1. For codes 8 to 15 it is 0.
- R3: For codes 0 to 7, the overflow flag is 1 exactly when A and Y have equal most significant bits and the sum's most significant bit differs from them. For codes 8 to 15 it is 0.
- R4: Code 8 gives A AND B, code 9 gives A OR B, code 10 gives A XOR B, and code 11 gives NOT A.
- R5: Code 12 passes B to the result unchanged.
- R6: Code 13 shifts B right by one position and fills the most significant bit from the right-shift fill input.
- R7: Code 14 shifts B left by one position and fills bit 0 from the left-shift fill input.
- R8: Under every code, the right serial output equals bit 0 of B and the left serial output equals the most significant bit of B.
- R9: For codes 0 to 14, the negative flag equals the result's most significant bit, and the zero flag is 1 exactly when the result is all zeros.
- R10: Code 15 gives a result of zero, with all four flags at 0, the zero flag included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, also the shifter input |
| fs_i | input | 4 | Function code |
| fill_r_i | input | 1 | Bit shifted into the MSB on a right shift |
| fill_l_i | input | 1 | Bit shifted into the LSB on a left shift |
| f_o | output | WIDTH | Result |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| ser_r_o | output | 1 | Bit leaving B at the LSB end |
| ser_l_o | output | 1 | Bit leaving B at the MSB end |

## Verification
The bench instantiates the unit twice. A 4-bit copy is driven through every combination of A, B and function code, each combination with several fill-bit pairs. This reaches every carry and overflow corner and every shift fill case exhaustively. An 8-bit copy receives seeded random operands and directed cases at the signed limits: largest positive plus one, most negative minus one, increment of all ones, and shifts of alternating patterns. These confirm that the flag rules and the shifter's edge bits scale with WIDTH.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [3:0] {
        FN_PASS_A  = 4'd0,
        FN_INC     = 4'd1,
        FN_ADD     = 4'd2,
        FN_ADD_C   = 4'd3,
        FN_ADD_NB  = 4'd4,
        FN_SUB     = 4'd5,
        FN_DEC     = 4'd6,
        FN_PASS_A1 = 4'd7,
        FN_AND     = 4'd8,
        FN_OR      = 4'd9,
        FN_XOR     = 4'd10,
        FN_NOT_A   = 4'd11,
        FN_SH_PASS = 4'd12,
        FN_SH_R    = 4'd13,
        FN_SH_L    = 4'd14,
        FN_NULL    = 4'd15
    } fn_e;

    typedef enum logic [1:0] {
        YSEL_ZERO = 2'b00,
        YSEL_B    = 2'b01,
        YSEL_NB   = 2'b10,
        YSEL_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_ZERO  = 2'b11
    } shop_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       ysel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;
    localparam int EXT = WIDTH + 1;

    logic [WIDTH-1:0] y_d;
    logic [EXT-1:0]   total_d;

    always_comb begin
        unique case (ysel_i)
            YSEL_ZERO: y_d = '0;
            YSEL_B:    y_d = b_i;
            YSEL_NB:   y_d = ~b_i;
            default:   y_d = '1;
        endcase
        total_d = {1'b0, a_i} + {1'b0, y_d} + EXT'(cin_i);
        sum_o   = total_d[WIDTH-1:0];
        cout_o  = total_d[WIDTH];
        ovf_o   = (a_i[MSB] == y_d[MSB]) && (total_d[MSB] != a_i[MSB]);

        if (ysel_i == YSEL_NB && cin_i) begin
            p_sub_diff_r1: assert (sum_o == WIDTH'(a_i - b_i))
                else $error("subtract result mismatch");
        end
        if (ysel_i == YSEL_ZERO && !cin_i) begin
            p_pass_nocarry_r2: assert (sum_o == a_i && !cout_o)
                else $error("pass A produced carry or change");
        end
        if (ysel_i == YSEL_ONES && cin_i) begin
            p_wrap_carry_r2: assert (sum_o == a_i && cout_o)
                else $error("A + ones + 1 must carry and return A");
        end
        if (ysel_i == YSEL_ZERO) begin
            p_inc_ovf_r3: assert (ovf_o == (cin_i && a_i == {1'b0, {MSB{1'b1}}}))
                else $error("increment overflow rule broken");
        end
    end

endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] res_o
);
    import fu_pkg::*;

    always_comb begin
        unique case (sel_i)
            LOP_AND: res_o = a_i & b_i;
            LOP_OR:  res_o = a_i | b_i;
            LOP_XOR: res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase

        if (sel_i == LOP_XOR) begin
            p_xor_inverse_r4: assert ((res_o ^ a_i) == b_i)
                else $error("xor result not invertible");
        end
        if (sel_i == LOP_NOT) begin
            p_not_cover_r4: assert ((res_o & a_i) == '0 && (res_o | a_i) == '1)
                else $error("not result overlaps A");
        end
        if (sel_i == LOP_AND) begin
            p_and_subset_r4: assert ((res_o & ~b_i) == '0 && (res_o & ~a_i) == '0)
                else $error("and result exceeds operands");
        end
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    input  logic             fill_r_i,
    input  logic             fill_l_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ser_r_o,
    output logic             ser_l_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] from_left_d;
    logic [WIDTH-1:0] from_right_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == MSB) begin : g_top
            assign from_left_d[i] = fill_r_i;
        end else begin : g_mid_r
            assign from_left_d[i] = b_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_right_d[i] = fill_l_i;
        end else begin : g_mid_l
            assign from_right_d[i] = b_i[i-1];
        end
        always_comb begin
            unique case (sel_i)
                SH_PASS:  res_o[i] = b_i[i];
                SH_RIGHT: res_o[i] = from_left_d[i];
                SH_LEFT:  res_o[i] = from_right_d[i];
                default:  res_o[i] = 1'b0;
            endcase
        end
    end

    assign ser_r_o = b_i[0];
    assign ser_l_o = b_i[MSB];

    always_comb begin
        if (sel_i == SH_RIGHT) begin
            p_right_chain_r6: assert ({res_o, ser_r_o} == {fill_r_i, b_i})
                else $error("right shift loses a bit");
        end
        if (sel_i == SH_LEFT) begin
            p_left_chain_r7: assert ({ser_l_o, res_o} == {b_i, fill_l_i})
                else $error("left shift loses a bit");
        end
    end

endmodule

// File: rtl/fu_unit.sv
module fu_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       fs_i,
    input  logic             fill_r_i,
    input  logic             fill_l_i,
    output logic [WIDTH-1:0] f_o,
    output logic             v_o,
    output logic             c_o,
    output logic             n_o,
    output logic             z_o,
    output logic             ser_r_o,
    output logic             ser_l_o
);
    import fu_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] f;
        flags_t           fl;
    } unit_out_t;

    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic             arith_ovf;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    unit_out_t        out_d;

    fu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .ysel_i (fs_i[2:1]),
        .cin_i  (fs_i[0]),
        .sum_o  (arith_sum),
        .cout_o (arith_cout),
        .ovf_o  (arith_ovf)
    );

    fu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (fs_i[1:0]),
        .res_o (logic_res)
    );

    fu_shift #(.WIDTH(WIDTH)) u_shift (
        .b_i      (b_i),
        .sel_i    (fs_i[1:0]),
        .fill_r_i (fill_r_i),
        .fill_l_i (fill_l_i),
        .res_o    (shift_res),
        .ser_r_o  (ser_r_o),
        .ser_l_o  (ser_l_o)
    );

    always_comb begin
        out_d = '0;
        if (fs_i == FN_NULL) begin
            out_d = '0;
        end else begin
            if (fs_i[3] && fs_i[2]) begin
                out_d.f = shift_res;
            end else if (fs_i[3]) begin
                out_d.f = logic_res;
            end else begin
                out_d.f    = arith_sum;
                out_d.fl.c = arith_cout;
                out_d.fl.v = arith_ovf;
            end
            out_d.fl.n = out_d.f[MSB];
            out_d.fl.z = (out_d.f == '0);
        end
    end

    assign f_o = out_d.f;
    assign v_o = out_d.fl.v;
    assign c_o = out_d.fl.c;
    assign n_o = out_d.fl.n;
    assign z_o = out_d.fl.z;

    always_comb begin
        if (fs_i == FN_NULL) begin
            p_null_clear_r10: assert (f_o == '0 && !v_o && !c_o && !n_o && !z_o)
                else $error("null code left output or flags set");
        end
        if (fs_i[3]) begin
            p_no_arith_flags_r2: assert (!c_o && !v_o)
                else $error("carry or overflow outside arithmetic");
        end
        if (fs_i == FN_SH_PASS) begin
            p_pass_sign_r9: assert (n_o == b_i[MSB] && f_o == b_i)
                else $error("pass B sign or value wrong");
        end
        if (fs_i == FN_PASS_A) begin
            p_pass_zero_r9: assert (z_o == (a_i == '0))
                else $error("zero flag wrong on pass A");
        end
    end

endmodule

// File: tb/fu_unit_tb.sv
module fu_unit_tb;

    localparam int WW = 8;
    localparam int WN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [WW-1:0] aw, bw, fw;
    logic [WN-1:0] an, bn, fn;
    logic [3:0]    fs;
    logic          fill_r, fill_l;
    logic          vw, cw, nw, zw, srw, slw;
    logic          vn, cn, nn, zn, srn, sln;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fu_unit #(.WIDTH(WW)) u_dut (
        .a_i(aw), .b_i(bw), .fs_i(fs), .fill_r_i(fill_r), .fill_l_i(fill_l),
        .f_o(fw), .v_o(vw), .c_o(cw), .n_o(nw), .z_o(zw),
        .ser_r_o(srw), .ser_l_o(slw)
    );

    fu_unit #(.WIDTH(WN)) u_dut_narrow (
        .a_i(an), .b_i(bn), .fs_i(fs), .fill_r_i(fill_r), .fill_l_i(fill_l),
        .f_o(fn), .v_o(vn), .c_o(cn), .n_o(nn), .z_o(zn),
        .ser_r_o(srn), .ser_l_o(sln)
    );

    function automatic void model(input int w, input longint a, input longint b,
                                  input int code, input bit ir, input bit il,
                                  output longint f, output bit v, output bit c,
                                  output bit n, output bit z, output bit sr, output bit sl);
        longint mask = (longint'(1) << w) - 1;
        longint msb  = longint'(1) << (w - 1);
        longint y;
        longint full;
        v = 0; c = 0; f = 0;
        if (code < 8) begin
            case ((code >> 1) & 3)
                0: y = 0;
                1: y = b;
                2: y = ~b & mask;
                default: y = mask;
            endcase
            full = a + y + (code & 1);
            f = full & mask;
            c = ((full >> w) & 1) != 0;
            v = ((a & msb) == (y & msb)) && ((f & msb) != (a & msb));
        end else begin
            case (code)
                8:  f = a & b;
                9:  f = a | b;
                10: f = a ^ b;
                11: f = ~a & mask;
                12: f = b;
                13: f = (b >> 1) | (ir ? msb : 0);
                14: f = ((b << 1) & mask) | longint'(il);
                default: f = 0;
            endcase
        end
        n = (code != 15) && ((f & msb) != 0);
        z = (code != 15) && (f == 0);
        sr = (b & 1) != 0;
        sl = (b & msb) != 0;
    endfunction

    function automatic string res_req(input int code);
        if (code < 8)        return "R1";
        else if (code < 12)  return "R4";
        else if (code == 12) return "R5";
        else if (code == 13) return "R6";
        else if (code == 14) return "R7";
        return "R10";
    endfunction

    task automatic check(input string req, input string what, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            if (n_fail <= 30)
                $display("FAIL %s %s: actual %0h expected %0h (fs=%0d)", req, what, got, exp, fs);
        end
    endtask

    task automatic check_unit(input int w, input longint a, input longint b, input longint f_got,
                              input bit v_got, input bit c_got, input bit n_got, input bit z_got,
                              input bit sr_got, input bit sl_got);
        longint f;
        bit v, c, n, z, sr, sl;
        string flag_req;
        model(w, a, b, int'(fs), fill_r, fill_l, f, v, c, n, z, sr, sl);
        flag_req = (fs == 4'd15) ? "R10" : "R9";
        check(res_req(int'(fs)), "result", f_got, f);
        check("R2", "carry", longint'(c_got), longint'(c));
        check("R3", "overflow", longint'(v_got), longint'(v));
        check(flag_req, "negative", longint'(n_got), longint'(n));
        check(flag_req, "zero", longint'(z_got), longint'(z));
        check("R8", "serial right", longint'(sr_got), longint'(sr));
        check("R8", "serial left", longint'(sl_got), longint'(sl));
    endtask

    task automatic apply(input logic [WW-1:0] a8, input logic [WW-1:0] b8,
                         input logic [WN-1:0] a4, input logic [WN-1:0] b4,
                         input logic [3:0] code, input logic ir, input logic il);
        @(negedge clk);
        aw = a8; bw = b8; an = a4; bn = b4; fs = code; fill_r = ir; fill_l = il;
        #1;
        check_unit(WW, longint'(aw), longint'(bw), longint'(fw), vw, cw, nw, zw, srw, slw);
        check_unit(WN, longint'(an), longint'(bn), longint'(fn), vn, cn, nn, zn, srn, sln);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        aw = '0; bw = '0; an = '0; bn = '0; fs = '0; fill_r = 0; fill_l = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // after reset with all-zero inputs: pass A of zero, zero flag set (R9)
        check("R9", "reset zero flag", longint'(zw), 1);
        check("R1", "reset result", longint'(fw), 0);

        // directed wide corners
        apply(8'h7F, 8'h01, 4'h1, 4'h1, 4'd2, 0, 0);  // R3 positive overflow
        apply(8'h80, 8'h01, 4'h8, 4'h1, 4'd5, 0, 0);  // R3 negative overflow on subtract
        apply(8'hFF, 8'h00, 4'hF, 4'h0, 4'd1, 0, 0);  // R2 increment carry, zero
        apply(8'h00, 8'h00, 4'h0, 4'h0, 4'd6, 0, 0);  // R1 decrement wraps
        apply(8'h12, 8'hA5, 4'h2, 4'hA, 4'd13, 1, 0); // R6 fill MSB
        apply(8'h12, 8'hA5, 4'h2, 4'hA, 4'd14, 0, 1); // R7 fill LSB
        apply(8'h12, 8'h81, 4'h2, 4'h9, 4'd12, 1, 1); // R5 and R8
        apply(8'h3C, 8'h81, 4'h3, 4'h9, 4'd15, 1, 1); // R10
        apply(8'h3C, 8'h0F, 4'h3, 4'h6, 4'd11, 0, 0); // R4 not

        // exhaustive narrow sweep with random wide operands
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int fl = 0; fl < 4; fl++) begin
                        apply(WW'($urandom), WW'($urandom), WN'(a), WN'(b), 4'(c),
                              fl[0], fl[1]);
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule